// File: doc/BRIEF.md
# Stereo and Interlace Video Timing Generator

This block produces the raster timing for a parallel pixel output: horizontal sync, vertical sync, a data-enable strobe and the column and row of the current active pixel. A line is built from a sync pulse, a back porch, the active span and a front porch, all counted in pixel clocks. Fields are built the same way from lines. The vertical figures come from one of four independent parameter sets, one for each combination of eye (left or right) and field parity (odd or even). Each set can delay its vertical sync by half a line.

Two mode inputs select progressive or interlaced scanning and mono or stereo output. The mode decides which parameter sets take part in the field sequence. Two outputs report the eye and the parity of the field now being scanned, so that downstream logic can fetch the matching source picture. All configuration is captured while a soft reset input is held. Releasing the soft reset restarts the raster at the first pixel of the first field. A separate enable input forces every output to its idle level while the counters keep running.

Top module: `stereo_vtg`

## Requirements
- R1: A line lasts `cfg_h_sync + cfg_h_back + cfg_h_active + cfg_h_front` clocks. Horizontal sync is active during the first `cfg_h_sync` clocks of each line.
- R2: `de` is active only where the column lies in `[sync+back, sync+back+active)` and the line also lies in its active window. There, `pix_x` and `pix_y` count from 0 within the active region. Outside it, both are 0.
- R3: A field that uses parameter set n lasts `sync[n] + back[n] + cfg_v_active + front[n]` lines. Without the half-line flag, vertical sync is active during its first `sync[n]` lines.
- R4: When `cfg_v_half[n]` is set, vertical sync for that field asserts at column `floor(line_length/2)` of line 0 and deasserts at the same column of line `sync[n]`. With `sync[n]` equal to 0 it never asserts.
- R5: The set index is 0 for left-odd, 1 for left-even, 2 for right-odd and 3 for right-even. Progressive mono repeats set 0 only. Interlaced mono alternates 0 and 1. Progressive stereo alternates 0 and 2. Interlaced stereo runs 0, 1, 2, 3 in turn. `eye_right` is bit 1 of the index and `field_even` is bit 0.
- R6: In `cfg_pol`, bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de. Bit 3 selects the falling output clock edge and is reported on `out_clk_inv`. A cleared bit means active-high, or the rising edge.
- R7: Configuration inputs are captured only while `soft_rst` is high. Changes made while it is low have no effect on the outputs.
- R8: While `soft_rst` is high, outputs sit at their idle levels with coordinates, eye and parity at 0. On the first clock after release, the outputs show line 0, column 0 of set 0.
- R9: While `enable` is low, hsync, vsync and de sit at their idle levels and the coordinates, eye and parity are 0. The counters keep running, so raising `enable` again resumes in phase.
- R10: Outputs are registered. The value seen after the k-th clock edge following release describes pixel k-1 of the raster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Holds timing at start and captures configuration |
| enable | input | 1 | Output gate; low forces idle levels |
| cfg_interlace | input | 1 | Interlaced scanning |
| cfg_stereo | input | 1 | Two-eye output |
| cfg_h_sync | input | HW | Horizontal sync width |
| cfg_h_back | input | HW | Horizontal back porch |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_front | input | HW | Horizontal front porch |
| cfg_v_active | input | VW | Active lines per field |
| cfg_v_sync | input | 4 x VW | Vertical sync width per set |
| cfg_v_back | input | 4 x VW | Vertical back porch per set |
| cfg_v_front | input | 4 x VW | Vertical front porch per set |
| cfg_v_half | input | 4 | Half-line vsync delay per set |
| cfg_pol | input | 4 | Polarity: hsync, vsync, de, clock edge |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | HW | Active column |
| pix_y | output | VW | Active row within the field |
| eye_right | output | 1 | Current field belongs to the right eye |
| field_even | output | 1 | Current field is the even field |
| out_clk_inv | output | 1 | Falling output clock edge selected |

## Verification
The hardest case to reach is a half-line-delayed vsync on a set other than the first. That case exists only deep into the field sequence, and only when the four sets differ. The bench therefore programs four sets with distinct sync widths, porches and shift flags on a tiny raster, and runs each mode through two complete sequences. It compares every output on every clock against an arithmetic model of the pixel index. In the interlaced stereo run it also scrambles the configuration inputs and drops enable for a window mid-run, then checks that the raster continues unchanged and in phase.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int NUM_SETS = 4;

    localparam int POL_HS = 0;
    localparam int POL_VS = 1;
    localparam int POL_DE = 2;
    localparam int POL_CK = 3;

    typedef enum logic [1:0] {
        SET_LO = 2'd0,
        SET_LE = 2'd1,
        SET_RO = 2'd2,
        SET_RE = 2'd3
    } vset_e;

    // Successor of a parameter set in the field sequence of the selected mode.
    function automatic vset_e next_set(vset_e cur, logic il, logic st);
        logic [1:0] inc;
        inc = 2'(cur) + 2'd1;
        case ({il, st})
            2'b11:   next_set = vset_e'(inc);
            2'b10:   next_set = (cur == SET_LO) ? SET_LE : SET_LO;
            2'b01:   next_set = (cur == SET_LO) ? SET_RO : SET_LO;
            default: next_set = SET_LO;
        endcase
    endfunction

endpackage

// File: rtl/vtg_cfg_latch.sv
module vtg_cfg_latch
    import vtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          il_i,
    input  logic                          st_i,
    input  logic [HW-1:0]                 h_sync_i,
    input  logic [HW-1:0]                 h_back_i,
    input  logic [HW-1:0]                 h_act_i,
    input  logic [HW-1:0]                 h_front_i,
    input  logic [VW-1:0]                 v_act_i,
    input  logic [NUM_SETS-1:0][VW-1:0]   v_sync_i,
    input  logic [NUM_SETS-1:0][VW-1:0]   v_back_i,
    input  logic [NUM_SETS-1:0][VW-1:0]   v_front_i,
    input  logic [NUM_SETS-1:0]           v_half_i,
    input  logic [3:0]                    pol_i,
    output logic                          il_q,
    output logic                          st_q,
    output logic [HW-1:0]                 h_sync_q,
    output logic [HW-1:0]                 h_back_q,
    output logic [HW-1:0]                 h_act_q,
    output logic [HW-1:0]                 h_front_q,
    output logic [VW-1:0]                 v_act_q,
    output logic [NUM_SETS-1:0][VW-1:0]   v_sync_q,
    output logic [NUM_SETS-1:0][VW-1:0]   v_back_q,
    output logic [NUM_SETS-1:0][VW-1:0]   v_front_q,
    output logic [NUM_SETS-1:0]           v_half_q,
    output logic [3:0]                    pol_q
);

    typedef struct packed {
        logic                        il;
        logic                        st;
        logic [HW-1:0]               h_sync;
        logic [HW-1:0]               h_back;
        logic [HW-1:0]               h_act;
        logic [HW-1:0]               h_front;
        logic [VW-1:0]               v_act;
        logic [NUM_SETS-1:0][VW-1:0] v_sync;
        logic [NUM_SETS-1:0][VW-1:0] v_back;
        logic [NUM_SETS-1:0][VW-1:0] v_front;
        logic [NUM_SETS-1:0]         v_half;
        logic [3:0]                  pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (soft_rst) begin
            cfg_d.il      = il_i;
            cfg_d.st      = st_i;
            cfg_d.h_sync  = h_sync_i;
            cfg_d.h_back  = h_back_i;
            cfg_d.h_act   = h_act_i;
            cfg_d.h_front = h_front_i;
            cfg_d.v_act   = v_act_i;
            cfg_d.v_sync  = v_sync_i;
            cfg_d.v_back  = v_back_i;
            cfg_d.v_front = v_front_i;
            cfg_d.v_half  = v_half_i;
            cfg_d.pol     = pol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign il_q      = cfg_q.il;
    assign st_q      = cfg_q.st;
    assign h_sync_q  = cfg_q.h_sync;
    assign h_back_q  = cfg_q.h_back;
    assign h_act_q   = cfg_q.h_act;
    assign h_front_q = cfg_q.h_front;
    assign v_act_q   = cfg_q.v_act;
    assign v_sync_q  = cfg_q.v_sync;
    assign v_back_q  = cfg_q.v_back;
    assign v_front_q = cfg_q.v_front;
    assign v_half_q  = cfg_q.v_half;
    assign pol_q     = cfg_q.pol;

    // R7: the captured pattern holds whenever soft reset is low
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(cfg_q));

endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [HW-1:0] h_sync,
    input  logic [HW-1:0] h_back,
    input  logic [HW-1:0] h_act,
    input  logic [HW-1:0] h_front,
    output logic [HW+1:0] hcnt,
    output logic [HW+1:0] half,
    output logic          line_end,
    output logic          hs_act,
    output logic          h_win,
    output logic [HW-1:0] x
);

    localparam int TW = HW + 2;
    localparam logic [TW-1:0] ONE = TW'(1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } hst_t;

    hst_t hst_d, hst_q;
    logic [TW-1:0] htot, a_start, a_end;

    always_comb begin
        htot     = {2'b00, h_sync} + {2'b00, h_back} + {2'b00, h_act} + {2'b00, h_front};
        a_start  = {2'b00, h_sync} + {2'b00, h_back};
        a_end    = a_start + {2'b00, h_act};
        line_end = (hst_q.cnt == htot - ONE);
        hst_d    = hst_q;
        if (soft_rst || line_end) hst_d.cnt = '0;
        else                      hst_d.cnt = hst_q.cnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hst_q <= '0;
        else        hst_q <= hst_d;
    end

    always_comb begin
        hcnt   = hst_q.cnt;
        half   = htot >> 1;
        hs_act = (hst_q.cnt < {2'b00, h_sync});
        h_win  = (hst_q.cnt >= a_start) && (hst_q.cnt < a_end);
        x      = h_win ? HW'(hst_q.cnt - a_start) : '0;
    end

    // R1: the counter returns to column 0 right after the last column
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && line_end) |=> (hst_q.cnt == '0));

    // R8: soft reset parks the counter at column 0
    a_r8_h_park: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (hst_q.cnt == '0));

endmodule

// File: rtl/vtg_vseq.sv
module vtg_vseq
    import vtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_rst,
    input  logic                        il,
    input  logic                        st,
    input  logic [HW+1:0]               hcnt,
    input  logic [HW+1:0]               half,
    input  logic                        line_end,
    input  logic [VW-1:0]               v_act,
    input  logic [NUM_SETS-1:0][VW-1:0] v_sync,
    input  logic [NUM_SETS-1:0][VW-1:0] v_back,
    input  logic [NUM_SETS-1:0][VW-1:0] v_front,
    input  logic [NUM_SETS-1:0]         v_half,
    output logic [1:0]                  set_idx,
    output logic                        vs_act,
    output logic                        v_win,
    output logic [VW-1:0]               y
);

    localparam int LW = VW + 2;
    localparam logic [LW-1:0] ONE = LW'(1);

    typedef struct packed {
        logic [LW-1:0] vcnt;
        vset_e         set;
    } vst_t;

    vst_t vst_d, vst_q;
    logic [LW-1:0] s_ext, b_ext, f_ext, vtot, v_start, v_end;
    logic          shift_on, field_end;

    always_comb begin
        s_ext     = {2'b00, v_sync[vst_q.set]};
        b_ext     = {2'b00, v_back[vst_q.set]};
        f_ext     = {2'b00, v_front[vst_q.set]};
        shift_on  = v_half[vst_q.set];
        vtot      = s_ext + b_ext + {2'b00, v_act} + f_ext;
        v_start   = s_ext + b_ext;
        v_end     = v_start + {2'b00, v_act};
        field_end = line_end && (vst_q.vcnt == vtot - ONE);

        vst_d = vst_q;
        if (soft_rst) begin
            vst_d.vcnt = '0;
            vst_d.set  = SET_LO;
        end else if (field_end) begin
            vst_d.vcnt = '0;
            vst_d.set  = next_set(vst_q.set, il, st);
        end else if (line_end) begin
            vst_d.vcnt = vst_q.vcnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vst_q <= '{vcnt: '0, set: SET_LO};
        else        vst_q <= vst_d;
    end

    always_comb begin
        set_idx = 2'(vst_q.set);
        v_win   = (vst_q.vcnt >= v_start) && (vst_q.vcnt < v_end);
        y       = v_win ? VW'(vst_q.vcnt - v_start) : '0;
        if (shift_on) begin
            vs_act = (s_ext != '0) &&
                     (((vst_q.vcnt == '0) && (hcnt >= half)) ||
                      ((vst_q.vcnt != '0) && (vst_q.vcnt < s_ext)) ||
                      ((vst_q.vcnt == s_ext) && (hcnt < half)));
        end else begin
            vs_act = (vst_q.vcnt < s_ext);
        end
    end

    // R5: the set changes only at the end of a field
    a_r5_set_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !field_end) |=> $stable(vst_q.set));

    // R5: progressive mono never leaves the left-odd set
    a_r5_mono_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!il && !st) |-> (vst_q.set == SET_LO));

    // R5: mono modes never select a right-eye set
    a_r5_mono_left: assert property (@(posedge clk) disable iff (!rst_n)
        !st |-> !vst_q.set[1]);

endmodule

// File: rtl/stereo_vtg.sv
module stereo_vtg
    import vtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_rst,
    input  logic                        enable,
    input  logic                        cfg_interlace,
    input  logic                        cfg_stereo,
    input  logic [HW-1:0]               cfg_h_sync,
    input  logic [HW-1:0]               cfg_h_back,
    input  logic [HW-1:0]               cfg_h_active,
    input  logic [HW-1:0]               cfg_h_front,
    input  logic [VW-1:0]               cfg_v_active,
    input  logic [NUM_SETS-1:0][VW-1:0] cfg_v_sync,
    input  logic [NUM_SETS-1:0][VW-1:0] cfg_v_back,
    input  logic [NUM_SETS-1:0][VW-1:0] cfg_v_front,
    input  logic [NUM_SETS-1:0]         cfg_v_half,
    input  logic [3:0]                  cfg_pol,
    output logic                        hsync,
    output logic                        vsync,
    output logic                        de,
    output logic [HW-1:0]               pix_x,
    output logic [VW-1:0]               pix_y,
    output logic                        eye_right,
    output logic                        field_even,
    output logic                        out_clk_inv
);

    logic                        il_q, st_q;
    logic [HW-1:0]               h_sync_q, h_back_q, h_act_q, h_front_q;
    logic [VW-1:0]               v_act_q;
    logic [NUM_SETS-1:0][VW-1:0] v_sync_q, v_back_q, v_front_q;
    logic [NUM_SETS-1:0]         v_half_q;
    logic [3:0]                  pol_q;

    logic [HW+1:0] hcnt, half;
    logic          line_end, hs_act, h_win, vs_act, v_win;
    logic [HW-1:0] x_raw;
    logic [VW-1:0] y_raw;
    logic [1:0]    set_idx;

    vtg_cfg_latch #(.HW(HW), .VW(VW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .il_i      (cfg_interlace),
        .st_i      (cfg_stereo),
        .h_sync_i  (cfg_h_sync),
        .h_back_i  (cfg_h_back),
        .h_act_i   (cfg_h_active),
        .h_front_i (cfg_h_front),
        .v_act_i   (cfg_v_active),
        .v_sync_i  (cfg_v_sync),
        .v_back_i  (cfg_v_back),
        .v_front_i (cfg_v_front),
        .v_half_i  (cfg_v_half),
        .pol_i     (cfg_pol),
        .il_q      (il_q),
        .st_q      (st_q),
        .h_sync_q  (h_sync_q),
        .h_back_q  (h_back_q),
        .h_act_q   (h_act_q),
        .h_front_q (h_front_q),
        .v_act_q   (v_act_q),
        .v_sync_q  (v_sync_q),
        .v_back_q  (v_back_q),
        .v_front_q (v_front_q),
        .v_half_q  (v_half_q),
        .pol_q     (pol_q)
    );

    vtg_hcount #(.HW(HW)) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .h_sync   (h_sync_q),
        .h_back   (h_back_q),
        .h_act    (h_act_q),
        .h_front  (h_front_q),
        .hcnt     (hcnt),
        .half     (half),
        .line_end (line_end),
        .hs_act   (hs_act),
        .h_win    (h_win),
        .x        (x_raw)
    );

    vtg_vseq #(.HW(HW), .VW(VW)) u_v (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .il       (il_q),
        .st       (st_q),
        .hcnt     (hcnt),
        .half     (half),
        .line_end (line_end),
        .v_act    (v_act_q),
        .v_sync   (v_sync_q),
        .v_back   (v_back_q),
        .v_front  (v_front_q),
        .v_half   (v_half_q),
        .set_idx  (set_idx),
        .vs_act   (vs_act),
        .v_win    (v_win),
        .y        (y_raw)
    );

    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic [HW-1:0] x;
        logic [VW-1:0] y;
        logic          eye;
        logic          fld;
    } out_t;

    out_t out_d, out_q;
    logic de_raw;

    always_comb begin
        de_raw = h_win && v_win;
        out_d  = '0;
        out_d.hs = pol_q[POL_HS];
        out_d.vs = pol_q[POL_VS];
        out_d.de = pol_q[POL_DE];
        if (!soft_rst && enable) begin
            out_d.hs  = hs_act ^ pol_q[POL_HS];
            out_d.vs  = vs_act ^ pol_q[POL_VS];
            out_d.de  = de_raw ^ pol_q[POL_DE];
            out_d.x   = de_raw ? x_raw : '0;
            out_d.y   = de_raw ? y_raw : '0;
            out_d.eye = set_idx[1];
            out_d.fld = set_idx[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hsync       = out_q.hs;
    assign vsync       = out_q.vs;
    assign de          = out_q.de;
    assign pix_x       = out_q.x;
    assign pix_y       = out_q.y;
    assign eye_right   = out_q.eye;
    assign field_even  = out_q.fld;
    assign out_clk_inv = pol_q[POL_CK];

    // R8: soft reset clears coordinates, eye and parity
    a_r8_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (pix_x == '0 && pix_y == '0 && !eye_right && !field_even));

    // R9: disable parks the strobes at their idle levels
    a_r9_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !soft_rst) |=> (de == pol_q[POL_DE] && hsync == pol_q[POL_HS]
                                    && vsync == pol_q[POL_VS]));

    // R2: data enable never overlaps the horizontal sync pulse
    a_r2_de_hs_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !$past(soft_rst)) |-> !((de != pol_q[POL_DE]) && (hsync != pol_q[POL_HS])));

endmodule

// File: tb/stereo_vtg_tb.sv
module stereo_vtg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 12;
    localparam int VW = 11;

    localparam int HS = 2, HB = 2, HA = 4, HF = 1;
    localparam int HT = HS + HB + HA + HF;
    localparam int HALF = HT / 2;
    localparam int VA = 3;

    logic clk = 1'b0;
    logic rst_n, soft_rst, enable, cfg_interlace, cfg_stereo;
    logic [HW-1:0] cfg_h_sync, cfg_h_back, cfg_h_active, cfg_h_front;
    logic [VW-1:0] cfg_v_active;
    logic [3:0][VW-1:0] cfg_v_sync, cfg_v_back, cfg_v_front;
    logic [3:0] cfg_v_half, cfg_pol;
    logic hsync, vsync, de, eye_right, field_even, out_clk_inv;
    logic [HW-1:0] pix_x;
    logic [VW-1:0] pix_y;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int vsy[4], vbk[4], vfr[4], vhf[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_vtg #(.HW(HW), .VW(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .cfg_interlace(cfg_interlace), .cfg_stereo(cfg_stereo),
        .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
        .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front),
        .cfg_v_active(cfg_v_active), .cfg_v_sync(cfg_v_sync),
        .cfg_v_back(cfg_v_back), .cfg_v_front(cfg_v_front),
        .cfg_v_half(cfg_v_half), .cfg_pol(cfg_pol),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .eye_right(eye_right), .field_even(field_even), .out_clk_inv(out_clk_inv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nxt(int idx, bit il, bit st);
        if (il && st) return (idx + 1) % 4;
        if (il)       return (idx == 0) ? 1 : 0;
        if (st)       return (idx == 0) ? 2 : 0;
        return 0;
    endfunction

    // Arithmetic model: pixel index since release -> expected raw timing
    task automatic model(input int p, input bit il, input bit st,
                         output bit e_hs, output bit e_vs, output bit e_de,
                         output int e_x, output int e_y, output int e_set);
        int idx, rem, flen, line, col;
        bit hw_on, vw_on;
        idx = 0;
        rem = p;
        while (1) begin
            flen = (vsy[idx] + vbk[idx] + VA + vfr[idx]) * HT;
            if (rem < flen) break;
            rem -= flen;
            idx = nxt(idx, il, st);
        end
        line  = rem / HT;
        col   = rem % HT;
        e_hs  = (col < HS);
        hw_on = (col >= HS + HB) && (col < HS + HB + HA);
        vw_on = (line >= vsy[idx] + vbk[idx]) && (line < vsy[idx] + vbk[idx] + VA);
        e_de  = hw_on && vw_on;
        e_x   = e_de ? col - HS - HB : 0;
        e_y   = e_de ? line - vsy[idx] - vbk[idx] : 0;
        if (vhf[idx] != 0)
            e_vs = (vsy[idx] != 0) && (rem >= HALF) && (rem < vsy[idx] * HT + HALF);
        else
            e_vs = (line < vsy[idx]);
        e_set = idx;
    endtask

    task automatic load_cfg(input bit il, input bit st, input logic [3:0] pol);
        cfg_interlace = il;
        cfg_stereo    = st;
        cfg_h_sync    = HW'(HS);
        cfg_h_back    = HW'(HB);
        cfg_h_active  = HW'(HA);
        cfg_h_front   = HW'(HF);
        cfg_v_active  = VW'(VA);
        for (int i = 0; i < 4; i++) begin
            cfg_v_sync[i]  = VW'(vsy[i]);
            cfg_v_back[i]  = VW'(vbk[i]);
            cfg_v_front[i] = VW'(vfr[i]);
            cfg_v_half[i]  = (vhf[i] != 0);
        end
        cfg_pol = pol;
    endtask

    task automatic scramble();
        cfg_interlace = 1'b0;
        cfg_stereo    = 1'b0;
        cfg_h_sync    = 12'd5;
        cfg_h_active  = 12'd9;
        cfg_v_active  = 11'd7;
        for (int i = 0; i < 4; i++) begin
            cfg_v_sync[i] = 11'd3;
            cfg_v_back[i] = 11'd4;
        end
        cfg_v_half = 4'b0000;
        cfg_pol    = ~cfg_pol;
    endtask

    task automatic run_mode(input bit il, input bit st, input logic [3:0] pol,
                            input int ncyc, input bit disturb);
        bit e_hs, e_vs, e_de;
        int e_x, e_y, e_set;
        load_cfg(il, st, pol);
        soft_rst = 1'b1;
        enable   = 1'b1;
        repeat (4) @(negedge clk);
        // R8 idle state under soft reset, R6 polarity of idle levels
        chk("R8 R6 hsync idle", hsync, pol[0]);
        chk("R8 R6 vsync idle", vsync, pol[1]);
        chk("R8 R6 de idle", de, pol[2]);
        chk("R8 pix_x zero", pix_x, 0);
        chk("R8 pix_y zero", pix_y, 0);
        chk("R8 eye zero", eye_right, 0);
        chk("R8 parity zero", field_even, 0);
        chk("R6 clock edge select", out_clk_inv, pol[3]);
        soft_rst = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            bit en_k;
            string tg;
            en_k   = !(disturb && k >= 100 && k < 130);
            enable = en_k;
            if (disturb && k == 60) scramble();
            tg = (disturb && k >= 60) ? " R7" : "";
            @(posedge clk);
            @(negedge clk);
            model(k - 1, il, st, e_hs, e_vs, e_de, e_x, e_y, e_set);
            if (en_k) begin
                chk({"R1 R10 hsync", tg}, hsync, e_hs ^ pol[0]);
                chk({(vhf[e_set] != 0) ? "R4 vsync" : "R3 vsync", tg}, vsync, e_vs ^ pol[1]);
                chk({"R2 de", tg}, de, e_de ^ pol[2]);
                chk({"R2 pix_x", tg}, pix_x, e_x);
                chk({"R2 pix_y", tg}, pix_y, e_y);
                chk({"R5 eye", tg}, eye_right, (e_set >> 1) & 1);
                chk({"R5 parity", tg}, field_even, e_set & 1);
            end else begin
                chk("R9 hsync gated", hsync, pol[0]);
                chk("R9 vsync gated", vsync, pol[1]);
                chk("R9 de gated", de, pol[2]);
                chk("R9 coords gated", int'(pix_x) + int'(pix_y), 0);
                chk("R9 eye parity gated", int'(eye_right) + int'(field_even), 0);
            end
            chk({"R6 clock edge", tg}, out_clk_inv, pol[3]);
        end
    endtask

    initial begin
        vsy = '{1, 2, 1, 1};
        vbk = '{1, 1, 2, 1};
        vfr = '{1, 2, 1, 1};
        vhf = '{0, 1, 0, 1};
        rst_n    = 1'b0;
        soft_rst = 1'b1;
        enable   = 1'b1;
        load_cfg(1'b0, 1'b0, 4'b0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5 progressive mono: six-line field of set 0 only
        run_mode(1'b0, 1'b0, 4'b0000, 130, 1'b0);
        // R5 interlaced mono: sets 0 and 1, the even field shifted (R4)
        run_mode(1'b1, 1'b0, 4'b0000, 280, 1'b0);
        // R5 progressive stereo with every polarity bit inverted (R6)
        run_mode(1'b0, 1'b1, 4'b1111, 260, 1'b0);
        // R5 interlaced stereo, config scramble (R7) and enable gap (R9)
        run_mode(1'b1, 1'b1, 4'b0101, 500, 1'b1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule